// File: doc/BRIEF.md
# Pipelined Multibit Trie Route Lookup

This block resolves an 8-bit destination address to an output port by walking a fixed-stride multibit trie. The trie has already been leaf-pushed in software, so every stored route is disjoint from every other. Each level of the trie sits in its own small memory, and each memory is read by its own pipeline stage. A stage only follows a child link or reports a port. No prefix lengths are compared anywhere.

One lookup may enter on every clock. Its answer leaves after exactly one cycle per trie level, together with the address it answers. A host write port loads trie rows one at a time, choosing the level and the row.

The stride set, the address width, the child index width and the port width are parameters. The default strides are three bits at the root, then two bits, then two bits, all taken from the most significant end of the address.

Top module: `trie_lpm_engine`

## Requirements
- R1: While reset is asserted, and after it is released, `res_valid` stays low until a lookup has been presented.
- R2: A lookup presented with `lk_valid` on a clock edge gives `res_valid` high exactly LEVELS edges later (3 by default), with `res_addr` equal to the presented address.
- R3: Lookups presented on consecutive cycles give results on consecutive cycles, in the same order, one result per lookup.
- R4: A leaf row reached at an upper level ends the walk. Its port is reported unchanged, whatever the lower-level memories hold.
- R5: An empty row (kind 2'b00) ends the walk as a miss. A miss is reported as `res_hit` low with `res_port` zero.
- R6: A link row (kind 2'b10) at level l hands child index c to level l+1. That level then reads row c*2^s(l+1) plus the next s(l+1) address bits. Level 0 always reads row equal to the top s0 address bits.
- R7: With a leaf-pushed trie of any route table loaded, every address returns the longest-prefix-match port of that table, or a miss when no route covers it.
- R8: A host write to a level is seen by lookups that read that level on later cycles. A lookup reading the same row in the cycle of the write sees the old entry.
- R9: A link row in the last level is reported as a miss.
- R10: The row entry layout is {kind[1:0], payload[2:0]}. Kind 2'b01 is a leaf whose port is payload[1:0]. Kind 2'b10 is a link whose child index is payload[2:0]. The reserved kind 2'b11 is treated as empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_addr | input | 8 | Destination address to look up |
| wr_en | input | 1 | Host row write strobe |
| wr_level | input | 2 | Trie level that the write targets |
| wr_row | input | 5 | Row index inside that level's memory |
| wr_entry | input | 5 | Row entry {kind, payload} |
| res_valid | output | 1 | A result is presented this cycle |
| res_addr | output | 8 | Address that the result answers |
| res_hit | output | 1 | A route matched |
| res_port | output | 2 | Output port of the match, zero on a miss |

## Verification
Any corrupted stage state shows up at the ports exactly LEVELS cycles after the affected lookup enters. A lost or duplicated valid bit gives a result that arrives early, late or unrequested. A wrong row index or a broken pass-through gives a port that disagrees with the software longest-prefix model for that address. Sweeping all 256 addresses over the sample table and over several random tables reaches every root row and every child node that was loaded. Directed tables cover links in the last level, the reserved kind, and a write that coincides with a lookup of the same row.

// File: rtl/trie_pkg.sv
package trie_pkg;

  typedef enum logic [1:0] {
    KIND_EMPTY = 2'b00,
    KIND_LEAF  = 2'b01,
    KIND_LINK  = 2'b10,
    KIND_RSVD  = 2'b11
  } row_kind_e;

  // stride of level l, packed as 4-bit fields, level 0 in the low nibble
  function automatic int stride_at(logic [31:0] s, int l);
    return int'(s[4*l +: 4]);
  endfunction

  // address bits consumed by the levels above l
  function automatic int bits_before(logic [31:0] s, int l);
    int acc;
    acc = 0;
    for (int i = 0; i < l; i++) acc += stride_at(s, i);
    return acc;
  endfunction

  // row index width of level l
  function automatic int row_bits(logic [31:0] s, int l, int node_w);
    return (l == 0) ? stride_at(s, l) : node_w + stride_at(s, l);
  endfunction

  function automatic int max_row_bits(logic [31:0] s, int levels, int node_w);
    int m;
    m = 1;
    for (int i = 0; i < levels; i++)
      if (row_bits(s, i, node_w) > m) m = row_bits(s, i, node_w);
    return m;
  endfunction

endpackage

// File: rtl/trie_level.sv
module trie_level
  import trie_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STRIDE = 2,
  parameter int OFFSET = 3,
  parameter int RW     = 5,
  parameter int NODE_W = 3,
  parameter int PORT_W = 2,
  parameter int PAY_W  = 3,
  parameter bit LAST   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic                in_done,
  input  logic                in_hit,
  input  logic [PORT_W-1:0]   in_port,
  input  logic [NODE_W-1:0]   in_node,
  input  logic                wr_en,
  input  logic [RW-1:0]       wr_row,
  input  logic [PAY_W+1:0]    wr_entry,
  output logic                out_valid,
  output logic [ADDR_W-1:0]   out_addr,
  output logic                out_done,
  output logic                out_hit,
  output logic [PORT_W-1:0]   out_port,
  output logic [NODE_W-1:0]   out_node
);

  localparam int ROWS  = 1 << RW;
  localparam int ENT_W = PAY_W + 2;

  logic [ENT_W-1:0]  mem [ROWS];
  logic [STRIDE-1:0] field;
  logic [RW-1:0]     rd_row;
  logic [ENT_W-1:0]  rd_entry;
  row_kind_e         rd_kind;
  logic [PAY_W-1:0]  rd_pay;

  logic              nxt_done;
  logic              nxt_hit;
  logic [PORT_W-1:0] nxt_port;
  logic [NODE_W-1:0] nxt_node;

  // row = child index scaled by the node size, plus this level's address field
  assign field    = in_addr[ADDR_W-1-OFFSET -: STRIDE];
  assign rd_row   = RW'({in_node, field});
  assign rd_entry = mem[rd_row];
  assign rd_kind  = row_kind_e'(rd_entry[ENT_W-1 -: 2]);
  assign rd_pay   = rd_entry[PAY_W-1:0];

  // host write port, visible to reads from the next cycle on
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_entry;
  end

  always_comb begin
    nxt_done = in_done;
    nxt_hit  = in_hit;
    nxt_port = in_port;
    nxt_node = '0;
    if (!in_done) begin
      case (rd_kind)
        KIND_LEAF: begin
          nxt_done = 1'b1;
          nxt_hit  = 1'b1;
          nxt_port = rd_pay[PORT_W-1:0];
        end
        KIND_LINK: begin
          if (LAST) begin
            nxt_done = 1'b1;
            nxt_hit  = 1'b0;
            nxt_port = '0;
          end else begin
            nxt_done = 1'b0;
            nxt_node = rd_pay[NODE_W-1:0];
          end
        end
        default: begin
          nxt_done = 1'b1;
          nxt_hit  = 1'b0;
          nxt_port = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr <= in_addr;
      out_done <= nxt_done;
      out_hit  <= nxt_hit;
      out_port <= nxt_port;
      out_node <= nxt_node;
    end
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R3
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  addr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr == $past(in_addr));
  // R4
  resolved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_done |=> out_done && out_hit == $past(in_hit) && out_port == $past(in_port));
  // R5
  miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_done && !out_hit |-> out_port == '0);

endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine
  import trie_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          LEVELS  = 3,
  parameter logic [31:0] STRIDES = 32'h0000_0223,
  parameter int          NODE_W  = 3,
  parameter int          PORT_W  = 2,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int PAY_W = (PORT_W > NODE_W) ? PORT_W : NODE_W,
  localparam int ENT_W = PAY_W + 2,
  localparam int ROW_W = max_row_bits(STRIDES, LEVELS, NODE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [ENT_W-1:0]  wr_entry,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_hit,
  output logic [PORT_W-1:0] res_port
);

  logic              c_valid [LEVELS+1];
  logic [ADDR_W-1:0] c_addr  [LEVELS+1];
  logic              c_done  [LEVELS+1];
  logic              c_hit   [LEVELS+1];
  logic [PORT_W-1:0] c_port  [LEVELS+1];
  logic [NODE_W-1:0] c_node  [LEVELS+1];

  assign c_valid[0] = lk_valid;
  assign c_addr[0]  = lk_addr;
  assign c_done[0]  = 1'b0;
  assign c_hit[0]   = 1'b0;
  assign c_port[0]  = '0;
  assign c_node[0]  = '0;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int S    = stride_at(STRIDES, l);
    localparam int OFF  = bits_before(STRIDES, l);
    localparam int RW_L = row_bits(STRIDES, l, NODE_W);

    logic lvl_wr;
    assign lvl_wr = wr_en && (wr_level == LVL_W'(l));

    trie_level #(
      .ADDR_W (ADDR_W),
      .STRIDE (S),
      .OFFSET (OFF),
      .RW     (RW_L),
      .NODE_W (NODE_W),
      .PORT_W (PORT_W),
      .PAY_W  (PAY_W),
      .LAST   (l == LEVELS - 1)
    ) u_level (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (c_valid[l]),
      .in_addr   (c_addr[l]),
      .in_done   (c_done[l]),
      .in_hit    (c_hit[l]),
      .in_port   (c_port[l]),
      .in_node   (c_node[l]),
      .wr_en     (lvl_wr),
      .wr_row    (wr_row[RW_L-1:0]),
      .wr_entry  (wr_entry),
      .out_valid (c_valid[l+1]),
      .out_addr  (c_addr[l+1]),
      .out_done  (c_done[l+1]),
      .out_hit   (c_hit[l+1]),
      .out_port  (c_port[l+1]),
      .out_node  (c_node[l+1])
    );
  end

  assign res_valid = c_valid[LEVELS];
  assign res_addr  = c_addr[LEVELS];
  assign res_hit   = c_hit[LEVELS];
  assign res_port  = c_port[LEVELS];

  // R9
  final_resolved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> c_done[LEVELS] && c_node[LEVELS] == '0);

endmodule

// File: tb/trie_lpm_engine_tb.sv
`timescale 1ns/1ps
module trie_lpm_engine_tb;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lk_valid;
  logic [7:0] lk_addr;
  logic       wr_en;
  logic [1:0] wr_level;
  logic [4:0] wr_row;
  logic [4:0] wr_entry;
  logic       res_valid;
  logic [7:0] res_addr;
  logic       res_hit;
  logic [1:0] res_port;

  always #2.5 clk = ~clk;

  trie_lpm_engine u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wr_en(wr_en), .wr_level(wr_level), .wr_row(wr_row), .wr_entry(wr_entry),
    .res_valid(res_valid), .res_addr(res_addr), .res_hit(res_hit), .res_port(res_port)
  );

  typedef struct {
    logic [7:0] a;
    bit         hit;
    logic [1:0] port;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  int pv[16];
  int pl[16];
  int pp[16];
  int np;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", "cycles", cyc, 150000);
      finish_run();
    end
  end

  // result monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && res_valid === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, "R3", "unrequested result addr", int'(res_addr), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc - e.cyc == LAT, "R2", "latency", cyc - e.cyc, LAT);
        check(res_addr == e.a, "R2", "result address", int'(res_addr), int'(e.a));
        check(res_hit == e.hit, e.tag, "hit", int'(res_hit), int'(e.hit));
        check(res_port == e.port, e.tag, "port", int'(res_port), int'(e.port));
      end
    end
  end

  // software longest-prefix match: {hit, port}
  function automatic logic [2:0] lpm(int a);
    int best;
    logic [2:0] r;
    best = -1;
    r = 3'b000;
    for (int i = 0; i < np; i++) begin
      if (pl[i] > best && ((a >> (8 - pl[i])) == pv[i])) begin
        best = pl[i];
        r = {1'b1, 2'(pp[i])};
      end
    end
    return r;
  endfunction

  function automatic bit uniform(int base, int len);
    logic [2:0] f;
    f = lpm(base << (8 - len));
    for (int a = 0; a < 256; a++)
      if ((a >> (8 - len)) == base && lpm(a) != f) return 0;
    return 1;
  endfunction

  function automatic logic [4:0] ent(int kind, int pay);
    return {2'(kind), 3'(pay)};
  endfunction

  task automatic idle();
    @(negedge clk);
    lk_valid = 0;
    wr_en = 0;
  endtask

  task automatic wr(int lvl, int row, logic [4:0] e);
    @(negedge clk);
    lk_valid = 0;
    wr_en = 1;
    wr_level = 2'(lvl);
    wr_row = 5'(row);
    wr_entry = e;
  endtask

  task automatic look_exp(logic [7:0] a, bit hit, logic [1:0] port, string tag);
    exp_t e;
    @(negedge clk);
    wr_en = 0;
    lk_valid = 1;
    lk_addr = a;
    e.a = a; e.hit = hit; e.port = port; e.cyc = cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic look(logic [7:0] a);
    logic [2:0] r;
    string tag;
    r = lpm(int'(a));
    if (uniform(int'(a) >> 5, 3) && r[2]) tag = "R4";
    else if (!r[2]) tag = "R5";
    else tag = "R7";
    look_exp(a, r[2], r[1:0], tag);
  endtask

  task automatic drain();
    idle();
    for (int i = 0; i < 20 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, "R3", "results outstanding", q.size(), 0);
  endtask

  task automatic clear_all();
    for (int r = 0; r < 8; r++) wr(0, r, ent(0, 0));
    for (int r = 0; r < 32; r++) wr(1, r, ent(0, 0));
    for (int r = 0; r < 32; r++) wr(2, r, ent(0, 0));
  endtask

  task automatic leaf_or_empty(int lvl, int row, int base, int len);
    logic [2:0] f;
    f = lpm(base << (8 - len));
    wr(lvl, row, f[2] ? ent(1, int'(f[1:0])) : ent(0, 0));
  endtask

  // leaf-pushed build with strides {3,2,2}
  task automatic load_trie();
    int n1;
    int n2;
    n1 = 0;
    n2 = 0;
    clear_all();
    for (int r0 = 0; r0 < 8; r0++) begin
      if (uniform(r0, 3)) leaf_or_empty(0, r0, r0, 3);
      else begin
        wr(0, r0, ent(2, n1));
        for (int r1 = 0; r1 < 4; r1++) begin
          int b1;
          b1 = (r0 << 2) | r1;
          if (uniform(b1, 5)) leaf_or_empty(1, n1 * 4 + r1, b1, 5);
          else begin
            wr(1, n1 * 4 + r1, ent(2, n2));
            for (int r2 = 0; r2 < 4; r2++)
              leaf_or_empty(2, n2 * 4 + r2, (b1 << 2) | r2, 7);
            n2++;
          end
        end
        n1++;
      end
    end
    check(n1 <= 8 && n2 <= 8, "R6", "child nodes needed", n2, 8);
    idle();
  endtask

  task automatic add(int v, int len, int port);
    pv[np] = v; pl[np] = len; pp[np] = port; np++;
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd20240611));
    rst_n = 0;
    lk_valid = 0; lk_addr = '0;
    wr_en = 0; wr_level = '0; wr_row = '0; wr_entry = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", "res_valid in reset", int'(res_valid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);

    // sample table
    np = 0;
    add(3'b000, 3, 0);      add(6'b000101, 6, 1);   add(7'b0001111, 7, 2);
    add(4'b0010, 4, 0);     add(5'b00111, 5, 2);    add(4'b0110, 4, 0);
    add(5'b01111, 5, 2);    add(1'b1, 1, 0);        add(4'b1001, 4, 0);
    add(5'b11011, 5, 2);    add(6'b110101, 6, 1);   add(6'b111101, 6, 1);
    add(7'b1111111, 7, 2);
    load_trie();
    // R7 R3: back-to-back sweep of every address
    for (int a = 0; a < 256; a++) look(8'(a));
    drain();

    // R8: write coinciding with a lookup of the same root row
    @(negedge clk);
    wr_en = 1; wr_level = 2'd0; wr_row = 5'd5; wr_entry = ent(1, 3);
    lk_valid = 1; lk_addr = 8'hA0;
    begin
      exp_t e;
      e.a = 8'hA0; e.hit = 1; e.port = 2'd0; e.cyc = cyc; e.tag = "R8";
      q.push_back(e);
    end
    look_exp(8'hA0, 1, 2'd3, "R8");
    look_exp(8'hB7, 1, 2'd3, "R8");
    drain();

    // directed: link depth, last-level link, reserved kind
    clear_all();
    wr(0, 0, ent(2, 2));
    wr(1, 2 * 4 + 0, ent(1, 1));
    wr(1, 2 * 4 + 1, ent(2, 5));
    wr(2, 5 * 4 + 2, ent(1, 2));
    wr(2, 5 * 4 + 3, ent(2, 1));
    wr(2, 5 * 4 + 0, ent(3, 1));
    wr(1, 2 * 4 + 2, ent(3, 2));
    look_exp(8'h00, 1, 2'd1, "R6");
    look_exp(8'h0C, 1, 2'd2, "R6");
    look_exp(8'h0E, 0, 2'd0, "R9");
    look_exp(8'h08, 0, 2'd0, "R10");
    look_exp(8'h10, 0, 2'd0, "R10");
    look_exp(8'h20, 0, 2'd0, "R5");
    drain();

    // random tables, sweeps with gaps plus random addresses
    for (int t = 0; t < 3; t++) begin
      np = 0;
      for (int i = 0; i < 8; i++) begin
        int len;
        len = 1 + int'($urandom % 7);
        add(int'($urandom) & ((1 << len) - 1), len, int'($urandom % 4));
      end
      load_trie();
      for (int a = 0; a < 256; a++) begin
        if ($urandom % 4 == 0) idle();
        look(8'(a));
      end
      for (int i = 0; i < 64; i++) look(8'($urandom));
      drain();
    end

    finish_run();
  end

endmodule